// File: doc/BRIEF.md
# Audio Clock Ratio Monitor

This block supervises the two clocks of a serial audio input, the bit clock and the frame (word-select) clock. It works in a fast reference clock domain. It samples both audio clocks through synchronizers and counts bit-clock rising edges between successive frame-clock rising edges. The result is a measured bit-clocks-per-frame ratio, which is checked for stability and range. The block also watches for a bit clock that has stopped. It compares an externally detected sample-rate code with the configured rate mode, and it compares the measured ratio against an optional configured ratio.

The four detection causes appear side by side in a status vector. They are also merged into a single clock-error flag, and each cause has its own ignore bit that keeps it out of that flag. An ignore bit never hides a cause from the status vector. A latch-enable input turns the status bits sticky, and a one-cycle clear pulse empties the sticky store.

Top module: `audio_clk_monitor`

## Requirements
- R1: The measured ratio equals the number of bit-clock rising edges seen between two consecutive frame-clock rising edges. It is 10 bits wide, output as a 2-bit upper part (`ratio_hi`) and an 8-bit lower part (`ratio_lo`). A count that would exceed 1023 saturates at 1023.
- R2: Status bit 1 (ratio invalid) is set unless the last two captured frame counts are equal. A frame whose count differs from the previous one sets it again until two frames agree.
- R3: Status bit 1 is also set when the stable ratio is below 32 or above 512; ratios from 32 to 512 inclusive are valid.
- R4: Status bit 0 (bit clock missing) rises once 1024 reference cycles pass with no bit-clock rising edge, and it falls after the next rising edge.
- R5: Status bit 2 (rate error) is set in auto mode (rate mode 0) when the detected rate code is 0. In any non-zero rate mode it is set when the detected code differs from the mode.
- R6: Status bit 3 (ratio mismatch) is set when the configured ratio code is one of 3, 5, 7, 9 or 11 (meaning 32, 64, 128, 256 or 512 bit clocks per frame), the ratio is stable, and the measured ratio differs from that value. Any other code disables the comparison.
- R7: `clk_err` is high exactly when some status bit is set whose ignore bit (same bit position) is clear. Ignore bits do not change the status vector.
- R8: With `latch_en` high, each status bit stays set after its cause goes away, until a one-cycle `sticky_clr` pulse. With `latch_en` low, the status is live.
- R9: After reset the measured ratio is 0, bit clock missing is clear and ratio invalid is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst | input | 1 | Synchronous active-high reset |
| bck_in | input | 1 | Audio bit clock, asynchronous |
| lrck_in | input | 1 | Audio frame clock, asynchronous |
| cfg_ratio_code | input | 4 | Configured ratio code (3/5/7/9/11 = 32..512, else no check) |
| cfg_rate_mode | input | 4 | Rate mode, 0 = auto |
| det_rate_code | input | 4 | Detected sample-rate code, 0 = none found |
| ignore_mask | input | 4 | Per-cause exclusion from `clk_err` |
| latch_en | input | 1 | Makes status bits sticky |
| sticky_clr | input | 1 | One-cycle clear of sticky status |
| ratio_hi | output | 2 | Upper two bits of measured ratio |
| ratio_lo | output | 8 | Lower eight bits of measured ratio |
| status | output | 4 | {mismatch, rate error, invalid, missing} |
| clk_err | output | 1 | Aggregate clock error |

## Verification
Frame trains are driven at ratios below, at and above both range limits: 16, 31, 32, 48, 64, 128, 256, 512, 513, 600 and 1000. These separate the edge counting, including the upper two bits, from the inclusive range decision. A train of equal frames followed by one longer frame shows that a changed count clears validity, and that two matching frames restore it. All 256 combinations of rate mode and detected code are swept, as are all 16 configured ratio codes and all 16 ignore masks. Each sweep is checked against arithmetic expectations. The bit clock is stopped just short of and just past the missing limit, with the latch both off and on, to separate live from sticky reporting.

// File: rtl/acm_pkg.sv
package acm_pkg;

    localparam int RATIO_W   = 10;
    localparam int CAUSES    = 4;
    localparam int MIN_RATIO = 32;
    localparam int MAX_RATIO = 512;

    // Bit positions in the status vector and the ignore mask
    typedef enum int unsigned {
        C_MISSING  = 0,
        C_INVALID  = 1,
        C_RATE     = 2,
        C_MISMATCH = 3
    } cause_e;

    // Configured ratio code to bit clocks per frame; zero means "no check"
    function automatic logic [RATIO_W-1:0] decode_ratio(input logic [3:0] code);
        logic [RATIO_W-1:0] r;
        case (code)
            4'd3:    r = RATIO_W'(32);
            4'd5:    r = RATIO_W'(64);
            4'd7:    r = RATIO_W'(128);
            4'd9:    r = RATIO_W'(256);
            4'd11:   r = RATIO_W'(512);
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic logic rate_fault(input logic [3:0] mode, input logic [3:0] det);
        return (mode == 4'd0) ? (det == 4'd0) : (det != mode);
    endfunction

endpackage

// File: rtl/acm_edge_sync.sv
module acm_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    output logic rise
);
    // sh[0] is the newest sample; sh[STAGES] holds the previous synchronized value
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], sig_in};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];

endmodule

// File: rtl/acm_frame_counter.sv
module acm_frame_counter #(
    parameter int W    = 10,
    parameter int RMIN = 32,
    parameter int RMAX = 512
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bck_rise,
    input  logic         frame_start,
    output logic [W-1:0] ratio,
    output logic         invalid
);
    localparam logic [W-1:0] MIN_V = W'(RMIN);
    localparam logic [W-1:0] MAX_V = W'(RMAX);

    logic [W-1:0] cnt_q, ratio_q, cur;
    logic         stable_q;

    always_comb begin
        cur = cnt_q;
        if (bck_rise && cnt_q != '1) cur = cnt_q + W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            ratio_q  <= '0;
            stable_q <= 1'b0;
        end else if (frame_start) begin
            ratio_q  <= cur;
            stable_q <= (cur == ratio_q);
            cnt_q    <= '0;
        end else begin
            cnt_q    <= cur;
        end
    end

    assign ratio   = ratio_q;
    assign invalid = !stable_q || (ratio_q < MIN_V) || (ratio_q > MAX_V);

    // R2: a frame whose count differs from the previous one leaves the ratio invalid
    a_r2_change_clears: assert property (@(posedge clk) disable iff (rst)
        (frame_start && cur != ratio_q) |=> invalid);

    // R1: the running count never wraps past its maximum
    a_r1_count_saturates: assert property (@(posedge clk) disable iff (rst)
        (!frame_start && cnt_q == '1) |=> (cnt_q == '1 || $past(frame_start)));

endmodule

// File: rtl/acm_miss_timer.sv
module acm_miss_timer #(
    parameter int LIMIT = 1024
) (
    input  logic clk,
    input  logic rst,
    input  logic bck_rise,
    output logic missing
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

    logic [CW-1:0] idle_q;

    always_ff @(posedge clk) begin
        if (rst)                 idle_q <= '0;
        else if (bck_rise)       idle_q <= '0;
        else if (idle_q != LIM_V) idle_q <= idle_q + CW'(1);
    end

    assign missing = (idle_q == LIM_V);

    // R4: a bit-clock edge always ends the missing indication on the next cycle
    a_r4_edge_clears: assert property (@(posedge clk) disable iff (rst)
        bck_rise |=> !missing);

endmodule

// File: rtl/audio_clk_monitor.sv
module audio_clk_monitor
    import acm_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MISS_LIMIT  = 1024
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bck_in,
    input  logic                 lrck_in,
    input  logic [3:0]           cfg_ratio_code,
    input  logic [3:0]           cfg_rate_mode,
    input  logic [3:0]           det_rate_code,
    input  logic [CAUSES-1:0]    ignore_mask,
    input  logic                 latch_en,
    input  logic                 sticky_clr,
    output logic [RATIO_W-9:0]   ratio_hi,
    output logic [7:0]           ratio_lo,
    output logic [CAUSES-1:0]    status,
    output logic                 clk_err
);
    logic               bck_rise, lrck_rise, missing, invalid;
    logic [RATIO_W-1:0] ratio, expect_ratio;
    logic [CAUSES-1:0]  live, sticky_q;

    acm_edge_sync #(.STAGES(SYNC_STAGES)) u_bck_sync (
        .clk(clk), .rst(rst), .sig_in(bck_in), .rise(bck_rise));

    acm_edge_sync #(.STAGES(SYNC_STAGES)) u_lrck_sync (
        .clk(clk), .rst(rst), .sig_in(lrck_in), .rise(lrck_rise));

    acm_frame_counter #(.W(RATIO_W), .RMIN(MIN_RATIO), .RMAX(MAX_RATIO)) u_frame (
        .clk(clk), .rst(rst), .bck_rise(bck_rise), .frame_start(lrck_rise),
        .ratio(ratio), .invalid(invalid));

    acm_miss_timer #(.LIMIT(MISS_LIMIT)) u_miss (
        .clk(clk), .rst(rst), .bck_rise(bck_rise), .missing(missing));

    assign expect_ratio = decode_ratio(cfg_ratio_code);

    always_comb begin
        live             = '0;
        live[C_MISSING]  = missing;
        live[C_INVALID]  = invalid;
        live[C_RATE]     = rate_fault(cfg_rate_mode, det_rate_code);
        live[C_MISMATCH] = (expect_ratio != '0) && !invalid && (ratio != expect_ratio);
    end

    always_ff @(posedge clk) begin
        if (rst || sticky_clr) sticky_q <= '0;
        else                   sticky_q <= sticky_q | live;
    end

    assign status   = latch_en ? (sticky_q | live) : live;
    assign clk_err  = |(status & ~ignore_mask);
    assign ratio_hi = ratio[RATIO_W-1:8];
    assign ratio_lo = ratio[7:0];

    // R8: without a clear, no sticky bit ever falls
    a_r8_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        !sticky_clr |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));

    // R3: a live valid report implies the ratio lies in the legal window
    a_r3_valid_in_range: assert property (@(posedge clk) disable iff (rst)
        (!latch_en && !status[C_INVALID]) |->
            (ratio >= RATIO_W'(MIN_RATIO) && ratio <= RATIO_W'(MAX_RATIO)));

    // R7: masking every cause silences the aggregate flag
    a_r7_all_ignored: assert property (@(posedge clk) disable iff (rst)
        (&ignore_mask) |-> !clk_err);

endmodule

// File: tb/audio_clk_monitor_tb.sv
`timescale 1ns/1ps
module audio_clk_monitor_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bck_in = 1'b0, lrck_in = 1'b0;
    logic [3:0] cfg_ratio_code = 4'd0, cfg_rate_mode = 4'd9, det_rate_code = 4'd9;
    logic [3:0] ignore_mask = 4'd0;
    logic       latch_en = 1'b0, sticky_clr = 1'b0;
    logic [1:0] ratio_hi;
    logic [7:0] ratio_lo;
    logic [3:0] status;
    logic       clk_err;

    int tests = 0, fails = 0;
    localparam int HALF = 2;   // reference cycles per bit-clock half period

    always #2.5 clk = ~clk;

    audio_clk_monitor u_dut (
        .clk(clk), .rst(rst), .bck_in(bck_in), .lrck_in(lrck_in),
        .cfg_ratio_code(cfg_ratio_code), .cfg_rate_mode(cfg_rate_mode),
        .det_rate_code(det_rate_code), .ignore_mask(ignore_mask),
        .latch_en(latch_en), .sticky_clr(sticky_clr),
        .ratio_hi(ratio_hi), .ratio_lo(ratio_lo), .status(status), .clk_err(clk_err));

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bck_cycle();
        bck_in = 1'b0;
        repeat (HALF) @(negedge clk);
        bck_in = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic one_frame(input int n);
        for (int i = 0; i < n; i++) begin
            if (i == 0)     lrck_in = 1'b1;
            if (i == n / 2) lrck_in = 1'b0;
            bck_cycle();
        end
    endtask

    task automatic close_frame();
        bck_in  = 1'b0;
        lrck_in = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic open_train();
        lrck_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic run_ratio(input int n);
        open_train();
        repeat (3) one_frame(n);
        close_frame();
    endtask

    function automatic int dec_code(input int c);
        if (c == 3 || c == 5 || c == 7 || c == 9 || c == 11) return 1 << (5 + (c - 3) / 2);
        return 0;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int ratios[11] = '{16, 31, 32, 48, 64, 128, 256, 512, 513, 600, 1000};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk("R9 ratio", {ratio_hi, ratio_lo}, 0);
        chk("R9 missing", status[0], 0);
        chk("R9 invalid", status[1], 1);

        // R1 / R3 ratio sweep
        foreach (ratios[k]) begin
            int n = ratios[k];
            run_ratio(n);
            chk("R1 ratio", {ratio_hi, ratio_lo}, n);
            chk("R1 upper part", ratio_hi, n >> 8);
            chk("R3 range", status[1], (n < 32 || n > 512) ? 1 : 0);
        end

        // R2 changed count clears validity, two equal frames restore it
        open_train();
        repeat (3) one_frame(64);
        one_frame(80);
        close_frame();
        chk("R2 ratio after change", {ratio_hi, ratio_lo}, 80);
        chk("R2 invalid after change", status[1], 1);
        run_ratio(80);
        chk("R2 valid after agreement", status[1], 0);

        // R6 configured ratio sweep against a measured 128
        run_ratio(128);
        for (int c = 0; c < 16; c++) begin
            cfg_ratio_code = 4'(c);
            @(negedge clk);
            chk("R6 mismatch", status[3], (dec_code(c) != 0 && dec_code(c) != 128) ? 1 : 0);
        end
        cfg_ratio_code = 4'd0;

        // R5 / R7 rate sweep; only the rate cause can be live here
        for (int m = 0; m < 16; m++) begin
            for (int d = 0; d < 16; d++) begin
                int re;
                cfg_rate_mode = 4'(m);
                det_rate_code = 4'(d);
                ignore_mask   = {1'b0, 1'(d & 1), 2'b00};
                re = (m == 0) ? (d == 0) : (d != m);
                #1;
                chk("R5 rate error", status[2], re);
                chk("R7 rate aggregate", clk_err, (re != 0 && (d & 1) == 0) ? 1 : 0);
                @(negedge clk);
            end
        end
        cfg_rate_mode = 4'd9;
        det_rate_code = 4'd9;
        ignore_mask   = 4'd0;

        // R4 missing limit: just short of and just past 1024 reference cycles
        run_ratio(64);
        repeat (988) @(negedge clk);
        chk("R4 not yet missing", status[0], 0);
        repeat (60) @(negedge clk);
        chk("R4 missing", status[0], 1);
        chk("R4 clock error", clk_err, 1);

        // R7 ignore sweep with only the missing cause live
        for (int g = 0; g < 16; g++) begin
            ignore_mask = 4'(g);
            #1;
            chk("R7 status kept", status, 1);
            chk("R7 missing aggregate", clk_err, (g & 1) ? 0 : 1);
            @(negedge clk);
        end
        ignore_mask = 4'd0;

        run_ratio(64);
        chk("R4 missing cleared", status[0], 0);
        chk("R8 live status", status, 0);

        // R8 sticky behaviour
        sticky_clr = 1'b1;
        @(negedge clk);
        sticky_clr = 1'b0;
        latch_en   = 1'b1;
        repeat (1100) @(negedge clk);
        chk("R8 missing seen", status[0], 1);
        run_ratio(64);
        chk("R8 missing held", status[0], 1);
        chk("R8 held raises error", clk_err, 1);
        sticky_clr = 1'b1;
        @(negedge clk);
        sticky_clr = 1'b0;
        @(negedge clk);
        chk("R8 cleared", status, 0);
        chk("R8 error cleared", clk_err, 0);
        latch_en = 1'b0;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule